// File: doc/BRIEF.md
# Board Self-Test Light Driver

This block gives a freshly assembled FPGA board a quick visible health check. Four slide switches go in. An eight-light bar and one common-anode seven-segment digit come out. Three of the switches each light a complementary pair of bar lights. The top two switches together light one more bar light. The last bar light blinks by itself, which shows that the clock and configuration are alive. The digit shows the four switch bits as one hexadecimal character.

The switch paths and the digit decoder are purely combinational. The only storage is a free-running divider with a synchronous reset. With the default 24-bit width and a 40 MHz clock, the blink period is 2^24 clocks, about 2.4 Hz. The decoder is a separate module so that other designs can reuse it.

Top module: `board_selftest`

## Requirements
- R1: For k = 0, 1, 2, `led[2k]` equals `sw[k]` in the same cycle, with no register in the path.
- R2: For k = 0, 1, 2, `led[2k+1]` equals the inverse of `sw[k]` in the same cycle.
- R3: `led[6]` is 1 only when `sw[3]` and `sw[2]` are both 1, and 0 for the other three combinations of those two switches.
- R4: A clock edge with `rst` high clears the divider, so `led[7]` reads 0 after that edge.
- R5: After reset is released, `led[7]` holds each level for exactly 2^(BLINK_BITS-1) clock cycles and then toggles. It starts at 0.
- R6: `seg[0]` through `seg[6]` drive segments a through g. The lit segments are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all seven, 9 abcdfg, A abcefg, b cdefg, C adef, d bcdeg, E adefg, F aefg.
- R7: The segment outputs are active low (0 = lit), so at least one output is 0 for every switch value.
- R8: The digit follows `sw` in the same cycle and ignores `rst` and the divider state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Board clock driving the divider |
| rst | input | 1 | Synchronous active-high reset of the divider |
| sw | input | 4 | Switch levels, bit 3 the most significant |
| led | output | 8 | Bar lights, 1 = lit |
| seg | output | 7 | Segment cathodes a..g on bits 0..6, 0 = lit |

## Verification
The bench walks all sixteen switch values and compares every bar light and every segment on every clock against its own model. A design that swapped a true/inverse pair, or used OR for the top-pair light, would mismatch on the mixed switch values. Glyphs b and d are looked up from segment-letter strings. A decoder that reused the 6 or 0 pattern would fail on those values, and a decoder with its polarity flipped would fail on every value. The divider is shortened in the bench, and it is reset a second time in mid-run. A blink that was off by one cycle, started high, or ignored reset would miss the model's computed toggle edges.

// File: rtl/board_selftest_pkg.sv
package board_selftest_pkg;
   localparam int SW_W  = 4;
   localparam int LED_W = 8;
   localparam int SEG_W = 7;
   localparam int PAIRS = SW_W - 1;

   typedef logic [SW_W-1:0]  sw_t;
   typedef logic [LED_W-1:0] led_t;
   typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/bt_hex_seg.sv
// Combinational hex digit to seven-segment decoder; bit 0 = segment a.
module bt_hex_seg
   import board_selftest_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  sw_t  digit,
   output seg_t seg
);
   seg_t lit;   // 1 = segment on, bit order g..a

   always_comb begin
      unique case (digit)
         4'h0: lit = 7'b0111111;
         4'h1: lit = 7'b0000110;
         4'h2: lit = 7'b1011011;
         4'h3: lit = 7'b1001111;
         4'h4: lit = 7'b1100110;
         4'h5: lit = 7'b1101101;
         4'h6: lit = 7'b1111101;
         4'h7: lit = 7'b0000111;
         4'h8: lit = 7'b1111111;
         4'h9: lit = 7'b1101111;
         4'hA: lit = 7'b1110111;
         4'hB: lit = 7'b1111100;
         4'hC: lit = 7'b0111001;
         4'hD: lit = 7'b1011110;
         4'hE: lit = 7'b1111001;
         default: lit = 7'b1110001;
      endcase
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign seg = ~lit;
      end else begin : g_high
         assign seg = lit;
      end
   endgenerate
endmodule

// File: rtl/bt_blink_div.sv
// Free-running binary divider; the top bit is the blink output.
module bt_blink_div #(
   parameter int BITS = 24
) (
   input  logic clk,
   input  logic rst,
   output logic blink
);
   logic [BITS-1:0] count;

   always_ff @(posedge clk) begin
      if (rst) count <= '0;
      else     count <= count + 1'b1;
   end

   assign blink = count[BITS-1];
endmodule

// File: rtl/bt_switch_leds.sv
// Switch-to-light mapping: complementary pairs plus an AND light.
module bt_switch_leds
   import board_selftest_pkg::*;
(
   input  sw_t                 sw,
   output logic [2*PAIRS:0]    lights
);
   genvar k;
   generate
      for (k = 0; k < PAIRS; k++) begin : g_pair
         assign lights[2*k]   =  sw[k];
         assign lights[2*k+1] = ~sw[k];
      end
   endgenerate

   assign lights[2*PAIRS] = sw[SW_W-1] & sw[SW_W-2];
endmodule

// File: rtl/board_selftest.sv
module board_selftest
   import board_selftest_pkg::*;
#(
   parameter int BLINK_BITS     = 24,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SW_W-1:0]  sw,
   output logic [LED_W-1:0] led,
   output logic [SEG_W-1:0] seg
);
   localparam int STATIC_LEDS = 2 * PAIRS + 1;

   generate
      if (BLINK_BITS < 2 || BLINK_BITS > 32) begin : g_bad_bits
         $error("BLINK_BITS must be within 2..32");
      end
      if (STATIC_LEDS + 1 != LED_W) begin : g_bad_leds
         $error("light bar width does not match switch count");
      end
   endgenerate

   logic [STATIC_LEDS-1:0] static_leds;
   logic                   blink;

   bt_switch_leds u_map (
      .sw     (sw),
      .lights (static_leds)
   );

   bt_blink_div #(.BITS(BLINK_BITS)) u_div (
      .clk   (clk),
      .rst   (rst),
      .blink (blink)
   );

   bt_hex_seg #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_dec (
      .digit (sw),
      .seg   (seg)
   );

   assign led = {blink, static_leds};
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
   parameter int BLINK_BITS     = 24,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input logic       clk,
   input logic       rst,
   input logic [3:0] sw,
   input logic [7:0] led,
   input logic [6:0] seg
);
   localparam logic [BLINK_BITS:0] HALF = (BLINK_BITS+1)'(1) << (BLINK_BITS-1);

   logic                prev_blink;
   logic [BLINK_BITS:0] run;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_blink <= 1'b0;
         run        <= '0;
      end else begin
         prev_blink <= led[7];
         if (led[7] != prev_blink) run <= 1;
         else                      run <= run + 1'b1;
      end
   end

   // R2: each pair is complementary
   assert_pairs_differ_R2: assert property (@(posedge clk) disable iff (rst)
      (led[0] != led[1]) && (led[2] != led[3]) && (led[4] != led[5]));

   // R3: AND light lit only with both top switches set
   assert_and_light_R3: assert property (@(posedge clk) disable iff (rst)
      led[6] |-> (sw[3] && sw[2]));

   // R4: reset clears the blink
   assert_reset_blink_R4: assert property (@(posedge clk)
      $past(rst) |-> !led[7]);

   // R5: each blink level lasts exactly the half period
   assert_blink_run_R5: assert property (@(posedge clk) disable iff (rst)
      (led[7] != prev_blink) |-> (run == HALF));

   assert_blink_bound_R5: assert property (@(posedge clk) disable iff (rst)
      run <= HALF);

   // R6: digit 8 lights every segment
   assert_eight_all_R6: assert property (@(posedge clk) disable iff (rst)
      (sw == 4'h8) |-> (seg == (SEG_ACTIVE_LOW ? 7'h00 : 7'h7F)));

   // R7: some segment always lit
   assert_some_lit_R7: assert property (@(posedge clk) disable iff (rst)
      seg != (SEG_ACTIVE_LOW ? 7'h7F : 7'h00));
endmodule

bind board_selftest bt_checker #(
   .BLINK_BITS     (BLINK_BITS),
   .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
) u_chk (
   .clk (clk),
   .rst (rst),
   .sw  (sw),
   .led (led),
   .seg (seg)
);

// File: tb/board_selftest_tb.sv
`timescale 1ns/1ps
module board_selftest_tb;
   localparam int BITS = 5;
   localparam int HALF = 1 << (BITS - 1);

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] sw  = 4'h0;
   logic [7:0] led;
   logic [6:0] seg;

   int total = 0;
   int bad   = 0;
   int tick  = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   board_selftest #(.BLINK_BITS(BITS), .SEG_ACTIVE_LOW(1'b1)) u_dut (
      .clk (clk), .rst (rst), .sw (sw), .led (led), .seg (seg)
   );

   // cycles since the last reset edge
   always @(posedge clk) begin
      if (rst) tick <= 0;
      else     tick <= tick + 1;
   end

   function automatic string glyph(input int d);
      case (d)
         0: return "abcdef";   1: return "bc";      2: return "abdeg";
         3: return "abcdg";    4: return "bcfg";    5: return "acdfg";
         6: return "acdefg";   7: return "abc";     8: return "abcdefg";
         9: return "abcdfg";   10: return "abcefg"; 11: return "cdefg";
         12: return "adef";    13: return "bcdeg";  14: return "adefg";
         default: return "aefg";
      endcase
   endfunction

   function automatic logic [6:0] expect_seg(input int d);
      string s = glyph(d);
      logic [6:0] v = 7'h7F;          // active low: all dark
      for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b0;
      return v;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s sw=%h tick=%0d actual=%h expected=%h", req, sw, tick, act, exp);
      end
   endtask

   // full comparison against the reference model
   task automatic compare_all(input bit blink_known);
      int v = sw;
      check("R1", {led[4], led[2], led[0]}, {5'b0, sw[2:0]});
      check("R2", {led[5], led[3], led[1]}, {5'b0, ~sw[2:0]});
      check("R3", led[6], (v >= 12) ? 8'd1 : 8'd0);
      if (blink_known) check("R5", led[7], ((tick / HALF) % 2 == 1) ? 8'd1 : 8'd0);
      check("R6", seg, expect_seg(v));
      check("R7", (seg != 7'h7F), 8'd1);
   endtask

   initial begin
      // reset state
      repeat (3) @(posedge clk);
      @(negedge clk) #0.5;
      check("R4", led[7], 8'd0);
      check("R8", seg, expect_seg(0));       // digit valid during reset
      rst = 1'b0;

      // sweep all sixteen values, several cycles each, compare every clock
      for (int v = 0; v < 16; v++) begin
         sw = v[3:0];
         for (int c = 0; c < 7; c++) begin
            @(negedge clk) #0.5;
            compare_all(1'b1);
         end
      end

      // mid-run reset: blink must return low, digit unaffected (R4, R8)
      sw = 4'hD;
      while (led[7] !== 1'b1) @(negedge clk);
      #0.5 rst = 1'b1;
      @(negedge clk) #0.5;
      check("R4", led[7], 8'd0);
      check("R8", seg, expect_seg(13));
      rst = 1'b0;

      // long walk with switch changes each cycle; watch several toggles
      for (int c = 0; c < 6 * HALF; c++) begin
         sw = 4'((c * 7 + 3) % 16);
         #0.5;
         compare_all(1'b1);
         @(negedge clk) #0.5;
         compare_all(1'b1);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule